// File: doc/BRIEF.md
# Instruction Cache Control and Status Register

This block is a 32-bit control and status register, reachable only in supervisor mode, that sits beside an instruction cache. Software writes it through a one-cycle write strobe with a data word and reads it through a combinational read port. Every access is qualified by a supervisor-mode input. The register holds two enables for the cache's parity logic: parity checking and parity error injection. Injection can only be turned on together with checking.

Three sticky status flags record events that the cache reports as single-cycle pulses: an invalidation snoop that removed a locked line, a lock-set operation that did not take effect, and a lock overflow. Once set, a flag stays set until software writes 0 to its bit position.

A two-step write sequence produces a one-cycle flash-clear pulse for every line lock bit. Software first writes 0 and then writes 1 to the flash-clear position. That position always reads 0.

Top module: `icache_ctl_reg`

Bit positions below are little-endian indices of `wdata` and `rdata`. Bit k here corresponds to bit 63−k in a 32–63 big-endian numbering.

## Requirements
- R1: After reset, `rdata` (read in supervisor mode) is 0, `par_en` and `inj_en` are 0, and `lock_flash_clr` is 0.
- R2: A supervisor write loads bit 16 (parity checking enable) from `wdata[16]`. The new value is visible on `rdata[16]` and `par_en` in the cycle after the write.
- R3: A supervisor write sets bit 15 (parity injection enable, also on `inj_en`) only if `wdata[15]` and `wdata[16]` are both 1. In every other case the write clears bit 15.
- R4: Bit 11 (snoop removed a locked line) is set by a pulse on `snoop_lock_inval`. It then holds until a supervisor write with `wdata[11]`=0.
- R5: Bit 10 (lock request failed) is set by a pulse on `lock_fail`. It then holds until a supervisor write with `wdata[10]`=0.
- R6: Bit 9 (lock overflow) is set by a pulse on `lock_ovf`. It then holds until a supervisor write with `wdata[9]`=0.
- R7: Writing 1 to a sticky flag leaves it unchanged. When a set event and a clearing write fall in the same cycle, the flag ends up set.
- R8: `rdata[8]` always reads 0. A supervisor write with `wdata[8]`=1 produces a one-cycle `lock_flash_clr` pulse in the next cycle only if an earlier supervisor write with `wdata[8]`=0 armed the sequence. Firing disarms the sequence. Writes of 1 while disarmed produce no pulse.
- R9: All bits other than 16, 15, 11, 10 and 9 read 0 whatever was written.
- R10: Writes made with `sup`=0 change no state and arm nothing. While `sup`=0, `rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| sup | input | 1 | Supervisor-mode qualifier for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational from register state) |
| snoop_lock_inval | input | 1 | Pulse: a snoop invalidated a locked line |
| lock_fail | input | 1 | Pulse: a lock-set operation did not take effect |
| lock_ovf | input | 1 | Pulse: lock overflow |
| par_en | output | 1 | Parity checking enable to the cache |
| inj_en | output | 1 | Parity error injection enable to the cache |
| lock_flash_clr | output | 1 | One-cycle pulse clearing every line lock bit |

## Verification
Each write or event lands at one clock edge. Its effect on `rdata`, `par_en`, `inj_en` and the flash-clear pulse is due right after that edge, so the results are one cycle late. The bench drives each stimulus half a cycle before the edge. It checks every result at the following falling edge, which is exactly the cycle the pulse is high. `rdata` is combinational on `sup`, so the bench samples it a short delay after changing `sup`, inside the same cycle.

// File: rtl/icr_pkg.sv
package icr_pkg;
    localparam int REG_W     = 32;
    localparam int NFLAG     = 3;
    localparam int BIT_PAR   = 16;
    localparam int BIT_INJ   = 15;
    localparam int FLAG_LSB  = 9;   // overflow=9, fail=10, snoop=11
    localparam int BIT_FLASH = 8;
    localparam logic [REG_W-1:0] RD_MASK =
        (REG_W'(1) << BIT_PAR) | (REG_W'(1) << BIT_INJ) |
        (REG_W'((1 << NFLAG) - 1) << FLAG_LSB);

    typedef struct packed {
        logic par;
        logic inj;
    } en_t;

    typedef struct packed {
        logic armed;
        logic pulse;
    } flash_t;
endpackage

// File: rtl/icr_enable_bits.sv
module icr_enable_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic w_par,
    input  logic w_inj,
    output logic par_o,
    output logic inj_o
);
    import icr_pkg::*;

    en_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            st_d.par = w_par;
            st_d.inj = w_inj & w_par;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_o = st_q.par;
    assign inj_o = st_q.inj;
endmodule

// File: rtl/icr_sticky.sv
module icr_sticky #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] flag_d, flag_q;

    for (genvar i = 0; i < W; i++) begin : g_flag
        always_comb begin
            flag_d[i] = flag_q[i];
            if (clr_i[i]) flag_d[i] = 1'b0;
            if (set_i[i]) flag_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;
endmodule

// File: rtl/icr_flash_seq.sv
module icr_flash_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic w_bit,
    output logic pulse_o,
    output logic armed_o
);
    import icr_pkg::*;

    flash_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr_ok) begin
            if (!w_bit) begin
                st_d.armed = 1'b1;
            end else if (st_q.armed) begin
                st_d.pulse = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign armed_o = st_q.armed;
endmodule

// File: rtl/icache_ctl_reg.sv
module icache_ctl_reg
    import icr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             sup,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             snoop_lock_inval,
    input  logic             lock_fail,
    input  logic             lock_ovf,
    output logic             par_en,
    output logic             inj_en,
    output logic             lock_flash_clr
);
    logic             wr_ok;
    logic [NFLAG-1:0] ev_set;
    logic [NFLAG-1:0] ev_clr;
    logic [NFLAG-1:0] flags_q;
    logic             armed_q;

    assign wr_ok  = wr_en & sup;
    assign ev_set = {snoop_lock_inval, lock_fail, lock_ovf};

    for (genvar i = 0; i < NFLAG; i++) begin : g_clr
        assign ev_clr[i] = wr_ok & ~wdata[FLAG_LSB+i];
    end

    icr_enable_bits u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (wr_ok),
        .w_par (wdata[BIT_PAR]),
        .w_inj (wdata[BIT_INJ]),
        .par_o (par_en),
        .inj_o (inj_en)
    );

    icr_sticky #(.W(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_set),
        .clr_i (ev_clr),
        .q_o   (flags_q)
    );

    icr_flash_seq u_flash (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .w_bit   (wdata[BIT_FLASH]),
        .pulse_o (lock_flash_clr),
        .armed_o (armed_q)
    );

    always_comb begin
        rdata = '0;
        if (sup) begin
            rdata[BIT_PAR]                  = par_en;
            rdata[BIT_INJ]                  = inj_en;
            rdata[FLAG_LSB +: NFLAG]        = flags_q;
        end
    end
endmodule

// File: rtl/icache_ctl_reg_chk.sv
module icache_ctl_reg_chk
    import icr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             sup,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] rdata,
    input logic             snoop_lock_inval,
    input logic             lock_fail,
    input logic             lock_ovf,
    input logic             par_en,
    input logic             inj_en,
    input logic             lock_flash_clr,
    input logic [NFLAG-1:0] flags_q,
    input logic             armed_q
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (par_en == 1'b0 && inj_en == 1'b0 && flags_q == '0));

    p_par_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sup) |=> (par_en == $past(wdata[BIT_PAR])));

    p_inj_needs_par_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en |-> par_en);

    p_snoop_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_lock_inval |=> flags_q[2]);

    p_fail_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_fail |=> flags_q[1]);

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ovf |=> flags_q[0]);

    p_flag_no_selfclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && sup)) |=> ((flags_q & ~$past(flags_q)) == '0 || $past(snoop_lock_inval || lock_fail || lock_ovf)) && ((~flags_q & $past(flags_q)) == '0));

    p_flash_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flash_clr |=> !lock_flash_clr);

    p_flash_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flash_clr |-> ($past(wr_en && sup && wdata[BIT_FLASH]) && !armed_q));

    p_flash_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BIT_FLASH] == 1'b0);

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~RD_MASK) == '0);

    p_user_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sup && !snoop_lock_inval && !lock_fail && !lock_ovf)
        |=> ($stable(par_en) && $stable(inj_en) && $stable(flags_q) && !lock_flash_clr));

    p_user_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sup |-> rdata == '0);
endmodule

bind icache_ctl_reg icache_ctl_reg_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .sup              (sup),
    .wdata            (wdata),
    .rdata            (rdata),
    .snoop_lock_inval (snoop_lock_inval),
    .lock_fail        (lock_fail),
    .lock_ovf         (lock_ovf),
    .par_en           (par_en),
    .inj_en           (inj_en),
    .lock_flash_clr   (lock_flash_clr),
    .flags_q          (flags_q),
    .armed_q          (armed_q)
);

// File: tb/icache_ctl_reg_tb.sv
`timescale 1ns/1ps
module icache_ctl_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        sup = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        snoop_lock_inval = 1'b0;
    logic        lock_fail = 1'b0;
    logic        lock_ovf = 1'b0;
    logic        par_en, inj_en, lock_flash_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic       m_par = 0, m_inj = 0, m_armed = 0, m_flash = 0;
    logic [2:0] m_flag = '0;

    always #2 clk = ~clk;

    icache_ctl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sup(sup), .wdata(wdata),
        .rdata(rdata), .snoop_lock_inval(snoop_lock_inval), .lock_fail(lock_fail),
        .lock_ovf(lock_ovf), .par_en(par_en), .inj_en(inj_en),
        .lock_flash_clr(lock_flash_clr)
    );

    function automatic logic [31:0] exp_rd(input logic s);
        logic [31:0] r;
        r = '0;
        if (s) begin
            r[16] = m_par;
            r[15] = m_inj;
            r[11:9] = m_flag;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, model update, then checks
    task automatic step(input logic w, input logic s, input logic [31:0] d, input logic [2:0] ev);
        logic ok;
        wr_en = w; sup = s; wdata = d;
        {snoop_lock_inval, lock_fail, lock_ovf} = ev;
        ok = w & s;
        m_flash = 1'b0;
        if (ok) begin
            m_par = d[16];
            m_inj = d[15] & d[16];
            m_flag = m_flag & d[11:9];
            if (!d[8]) m_armed = 1'b1;
            else if (m_armed) begin m_flash = 1'b1; m_armed = 1'b0; end
        end
        m_flag = m_flag | ev;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        {snoop_lock_inval, lock_fail, lock_ovf} = 3'b000;
        sup = 1'b1;
        #0.5;
        chk("R2/R3/R4/R5/R6/R7/R9 rdata", rdata, exp_rd(1'b1));
        chk("R2 par_en", 32'(par_en), 32'(m_par));
        chk("R3 inj_en", 32'(inj_en), 32'(m_inj));
        chk("R8 lock_flash_clr", 32'(lock_flash_clr), 32'(m_flash));
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 outputs", {29'h0, par_en, inj_en, lock_flash_clr}, 32'h0);

        // R2/R3 directed
        step(1, 1, 32'h0001_0000, 3'b000);           // par only
        step(1, 1, 32'h0000_8000, 3'b000);           // inj w/o par: R3 both clear
        chk("R3 inj without par", 32'(inj_en), 32'h0);
        step(1, 1, 32'h0001_8000, 3'b000);           // both
        chk("R3 inj with par", 32'(inj_en), 32'h1);
        // R9 reserved bits written as 1
        step(1, 1, 32'hFFFF_FFFF, 3'b000);
        chk("R9 reserved", rdata & ~32'h0001_8E00, 32'h0);
        // R4/R5/R6 sticky set, R7 write-1 holds
        step(0, 1, 32'h0, 3'b111);
        step(1, 1, 32'h0000_0E00, 3'b000);
        chk("R7 write one holds", rdata[11:9], 3'b111);
        step(1, 1, 32'h0000_0000, 3'b000);
        chk("R4 R5 R6 cleared by zero", rdata[11:9], 3'b000);
        // R7 set wins over clear
        step(1, 1, 32'h0, 3'b101);
        chk("R7 set wins", rdata[11:9], 3'b101);
        // R10 user write ignored, user read zero
        step(1, 0, 32'h0001_8000, 3'b000);
        chk("R10 user write", {30'h0, par_en, inj_en}, 32'h0);
        sup = 1'b0; #0.5;
        chk("R10 user read", rdata, 32'h0);
        sup = 1'b1;
        // R8 flash sequence (armed by the earlier 0 write)
        step(1, 1, 32'h0000_0100, 3'b000);
        chk("R8 pulse after arm", 32'(lock_flash_clr), 32'h1);
        step(0, 1, 32'h0, 3'b000);
        chk("R8 single cycle", 32'(lock_flash_clr), 32'h0);
        step(1, 1, 32'h0000_0100, 3'b000);
        chk("R8 no pulse unarmed", 32'(lock_flash_clr), 32'h0);
        step(1, 0, 32'h0000_0000, 3'b000);           // user arm ignored
        step(1, 1, 32'h0000_0100, 3'b000);
        chk("R10 user arm ignored", 32'(lock_flash_clr), 32'h0);
        step(1, 1, 32'h0000_0000, 3'b000);
        step(1, 1, 32'h0000_0000, 3'b000);
        step(1, 1, 32'h0000_0100, 3'b000);
        chk("R8 pulse after double arm", 32'(lock_flash_clr), 32'h1);
        chk("R8 reads zero", 32'(rdata[8]), 32'h0);

        // constrained random
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] d;
            logic [2:0]  ev;
            d = $urandom;
            ev = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            step(($urandom % 3) != 0, ($urandom % 5) != 0, d, ev);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule